// File: doc/BRIEF.md
# Accumulator Compare, Logic and Shift Unit

This unit forms the accumulator result for the register-to-register and register-to-immediate operations of a small 16-bit accumulator machine. It takes a left operand (the secondary register), a right operand (the accumulator) and an immediate word. A 5-bit operation code selects one function. The result is captured in an output register when the enable is high and held when it is low.

The machine has no condition flags. A comparison writes a full-width mask into the accumulator: all ones when the relation holds and all zeros when it does not. Signed and unsigned orderings are separate operations. For the operations that take an immediate, the accumulator is the left side and the immediate is the right side.

Top module: `accCompareUnit`

## Requirements
- R1: After reset the result output is 0x0000.
- R2: When `enable` is low the result holds its value, whatever the other inputs do. When `enable` is high the result is updated at the next rising clock edge from the inputs present at that edge.
- R3: Bitwise operations: opcode 0 gives left AND right, 1 gives left OR right, and 2 gives left XOR right.
- R4: Signed relations compare the operands as two's-complement values: opcode 3 EQ, 4 NE, 5 GE, 6 GT, 7 LE, 8 LT. Each one means left relation right. The result is 0xFFFF when the relation holds and 0x0000 when it does not.
- R5: Unsigned relations compare the operands as unsigned values: opcode 9 HS (>=), 10 HI (>), 11 LS (<=), 12 LO (<). The result uses the same mask encoding as R4.
- R6: Opcode 13 (logical NOT) gives 0xFFFF when `rightOp` is zero and 0x0000 otherwise. Opcode 14 gives the two's complement of `rightOp`, and opcode 15 gives its bitwise complement.
- R7: Opcode 16 gives left plus right and opcode 17 gives left minus right (not right minus left). Both wrap modulo 2^16.
- R8: Register shifts take `leftOp` as the value and the full 16-bit `rightOp` as the count: opcode 18 shifts left logically, 19 shifts right arithmetically (filling with the sign) and 20 shifts right logically (filling with zeros). A count of 16 or more gives 0 for the logical shifts, and gives the sign bit copied into all 16 bits for the arithmetic shift.
- R9: Immediate shifts take `rightOp` as the value and the low 8 bits of `immOp` as the count: opcode 21 shifts left logically, 22 shifts right arithmetically and 23 shifts right logically. The same rules for large counts apply as in R8.
- R10: Immediate forms take `rightOp` as the left side and `immOp` as the right side: opcodes 24, 25 and 26 give AND, OR and XOR. Opcodes 27 to 30 give the signed relations EQ, NE, GE and LT. Opcode 31 gives the unsigned relation LO.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rstN | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Capture strobe for the result register |
| opCode | input | 5 | Operation select |
| leftOp | input | 16 | Secondary register operand |
| rightOp | input | 16 | Accumulator operand |
| immOp | input | 16 | Immediate operand |
| result | output | 16 | Registered accumulator result |

## Verification
The hardest cases to reach from the ports are the points where the signed and unsigned orderings disagree, and shift counts whose high bits are set while the low bits look small (for example 0x0100). Random operands almost never produce equal values or hit exactly the 15/16 count boundary. The stimulus therefore mixes seeded random words with directed pairs: equal operands, 0x8000 against 0x7FFF, 0xFFFF against 0x0000, and counts of 15, 16 and 0x0100. Each of these goes through every compare and shift opcode.

// File: rtl/acc_pkg.sv
package acc_pkg;
  localparam int DataW = 16;
  localparam int OpW   = 5;

  typedef enum logic [2:0] {
    FnLogic, FnCmp, FnUnary, FnArith, FnShift
  } fnSel_e;

  typedef enum logic [2:0] {
    RelEq, RelNe, RelGe, RelGt, RelLe, RelLt
  } rel_e;

  typedef struct packed {
    fnSel_e     fn;
    logic [1:0] sub;
    rel_e       rel;
    logic       isSigned;
    logic       useImm;
    logic       shiftImm;
    logic       load;
  } ctrl_t;
endpackage

// File: rtl/acc_ctrl.sv
module acc_ctrl
  import acc_pkg::*;
#(
  parameter int OpWidth = OpW
) (
  input  logic [OpWidth-1:0] opCode,
  input  logic               enable,
  output ctrl_t              ctrl
);
  always_comb begin
    ctrl          = '0;
    ctrl.fn       = FnLogic;
    ctrl.rel      = RelEq;
    ctrl.load     = enable;
    case (opCode)
      5'd0, 5'd1, 5'd2: begin
        ctrl.fn  = FnLogic;
        ctrl.sub = opCode[1:0];
      end
      5'd3, 5'd4, 5'd5, 5'd6, 5'd7, 5'd8: begin
        ctrl.fn       = FnCmp;
        ctrl.isSigned = 1'b1;
        ctrl.rel      = rel_e'(3'(opCode - 5'd3));
      end
      5'd9:  begin ctrl.fn = FnCmp; ctrl.rel = RelGe; end
      5'd10: begin ctrl.fn = FnCmp; ctrl.rel = RelGt; end
      5'd11: begin ctrl.fn = FnCmp; ctrl.rel = RelLe; end
      5'd12: begin ctrl.fn = FnCmp; ctrl.rel = RelLt; end
      5'd13, 5'd14, 5'd15: begin
        ctrl.fn  = FnUnary;
        ctrl.sub = 2'(opCode - 5'd13);
      end
      5'd16, 5'd17: begin
        ctrl.fn  = FnArith;
        ctrl.sub = {1'b0, opCode[0]};
      end
      5'd18, 5'd19, 5'd20: begin
        ctrl.fn  = FnShift;
        ctrl.sub = 2'(opCode - 5'd18);
      end
      5'd21, 5'd22, 5'd23: begin
        ctrl.fn       = FnShift;
        ctrl.sub      = 2'(opCode - 5'd21);
        ctrl.shiftImm = 1'b1;
      end
      5'd24, 5'd25, 5'd26: begin
        ctrl.fn     = FnLogic;
        ctrl.sub    = 2'(opCode - 5'd24);
        ctrl.useImm = 1'b1;
      end
      5'd27, 5'd28, 5'd29: begin
        ctrl.fn       = FnCmp;
        ctrl.isSigned = 1'b1;
        ctrl.useImm   = 1'b1;
        ctrl.rel      = rel_e'(3'(opCode - 5'd27));
      end
      5'd30: begin
        ctrl.fn = FnCmp; ctrl.isSigned = 1'b1; ctrl.useImm = 1'b1; ctrl.rel = RelLt;
      end
      default: begin
        ctrl.fn = FnCmp; ctrl.useImm = 1'b1; ctrl.rel = RelLt;
      end
    endcase
  end

  // R3: codes 0..2 never select a compare
  always_comb begin
    if (opCode <= 5'd2) a_logic_sel_r3: assert (ctrl.fn == FnLogic);
  end
endmodule

// File: rtl/acc_shift.sv
module acc_shift #(
  parameter int Width = 16,
  parameter int CntW  = 16
) (
  input  logic [Width-1:0] value,
  input  logic [CntW-1:0]  count,
  input  logic [1:0]       kind,
  output logic [Width-1:0] shifted
);
  localparam int StageN = $clog2(Width);

  logic big;
  logic fill;
  logic [Width-1:0] stage [StageN+1];

  assign big  = |count[CntW-1:StageN];
  assign fill = (kind == 2'd1) ? value[Width-1] : 1'b0;
  assign stage[0] = value;

  for (genvar s = 0; s < StageN; s++) begin : g_stage
    localparam int Amt = 1 << s;
    always_comb begin
      if (!count[s])
        stage[s+1] = stage[s];
      else if (kind == 2'd0)
        stage[s+1] = {stage[s][Width-1-Amt:0], {Amt{1'b0}}};
      else
        stage[s+1] = {{Amt{fill}}, stage[s][Width-1:Amt]};
    end
  end

  assign shifted = big ? {Width{fill}} : stage[StageN];
endmodule

// File: rtl/acc_datapath.sv
module acc_datapath
  import acc_pkg::*;
#(
  parameter int Width = DataW
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctrl_t            ctrl,
  input  logic [Width-1:0] leftOp,
  input  logic [Width-1:0] rightOp,
  input  logic [Width-1:0] immOp,
  output logic [Width-1:0] result
);
  localparam int ImmCntW = 8;

  logic [Width-1:0] opA, opB, nextVal, logicVal, unaryVal, arithVal, shiftVal;
  logic [Width-1:0] shiftIn, shiftCnt;
  logic eq, ltS, ltU, lt, relTrue;

  assign opA = ctrl.useImm ? rightOp : leftOp;
  assign opB = ctrl.useImm ? immOp   : rightOp;

  always_comb begin
    case (ctrl.sub)
      2'd0:    logicVal = opA & opB;
      2'd1:    logicVal = opA | opB;
      default: logicVal = opA ^ opB;
    endcase
  end

  assign eq  = (opA == opB);
  assign ltS = ($signed(opA) < $signed(opB));
  assign ltU = (opA < opB);
  assign lt  = ctrl.isSigned ? ltS : ltU;

  always_comb begin
    case (ctrl.rel)
      RelEq:   relTrue = eq;
      RelNe:   relTrue = !eq;
      RelGe:   relTrue = !lt;
      RelGt:   relTrue = !lt && !eq;
      RelLe:   relTrue = lt || eq;
      default: relTrue = lt;
    endcase
  end

  always_comb begin
    case (ctrl.sub)
      2'd0:    unaryVal = {Width{rightOp == '0}};
      2'd1:    unaryVal = '0 - rightOp;
      default: unaryVal = ~rightOp;
    endcase
  end

  assign arithVal = ctrl.sub[0] ? (leftOp - rightOp) : (leftOp + rightOp);

  assign shiftIn  = ctrl.shiftImm ? rightOp : leftOp;
  assign shiftCnt = ctrl.shiftImm ? {{(Width-ImmCntW){1'b0}}, immOp[ImmCntW-1:0]} : rightOp;

  acc_shift #(.Width(Width), .CntW(Width)) u_shift (
    .value(shiftIn), .count(shiftCnt), .kind(ctrl.sub), .shifted(shiftVal)
  );

  always_comb begin
    case (ctrl.fn)
      FnLogic: nextVal = logicVal;
      FnCmp:   nextVal = {Width{relTrue}};
      FnUnary: nextVal = unaryVal;
      FnArith: nextVal = arithVal;
      default: nextVal = shiftVal;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          result <= '0;
    else if (ctrl.load) result <= nextVal;
  end

  // R2: no load means no change
  p_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    !ctrl.load |=> $stable(result));
  // R4: a compare writes a full mask
  p_mask_r4: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.load && ctrl.fn == FnCmp) |=> (result == '0 || result == '1));
  // R6: complement of zero is all ones
  p_not_zero_r6: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.load && ctrl.fn == FnUnary && ctrl.sub == 2'd2 && rightOp == '0) |=> (result == '1));
  // R8: logical shift by a huge count clears
  p_big_shift_r8: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.load && ctrl.fn == FnShift && !ctrl.shiftImm && ctrl.sub != 2'd1
     && rightOp >= Width) |=> (result == '0));
endmodule

// File: rtl/accCompareUnit.sv
module accCompareUnit
  import acc_pkg::*;
#(
  parameter int Width = DataW
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             enable,
  input  logic [OpW-1:0]   opCode,
  input  logic [Width-1:0] leftOp,
  input  logic [Width-1:0] rightOp,
  input  logic [Width-1:0] immOp,
  output logic [Width-1:0] result
);
  ctrl_t ctrl;

  acc_ctrl #(.OpWidth(OpW)) u_ctrl (
    .opCode(opCode), .enable(enable), .ctrl(ctrl)
  );

  acc_datapath #(.Width(Width)) u_dp (
    .clk(clk), .rstN(rstN), .ctrl(ctrl),
    .leftOp(leftOp), .rightOp(rightOp), .immOp(immOp), .result(result)
  );

  // R1: reset clears the result
  p_reset_r1: assert property (@(posedge clk) !rstN |=> (result == '0));
endmodule

// File: tb/sim_accCompareUnit.sv
module sim_accCompareUnit;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic enable = 1'b0;
  logic [4:0]  opCode = '0;
  logic [15:0] leftOp = '0, rightOp = '0, immOp = '0;
  logic [15:0] result;
  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  accCompareUnit u0 (.clk(clk), .rstN(rstN), .enable(enable), .opCode(opCode),
    .leftOp(leftOp), .rightOp(rightOp), .immOp(immOp), .result(result));

  function automatic logic [15:0] mask(input bit b);
    return b ? 16'hFFFF : 16'h0000;
  endfunction

  function automatic logic [15:0] shf(input logic [15:0] v, input int unsigned c, input int k);
    logic [15:0] r;
    r = v;
    if (c >= 16) return (k == 1) ? {16{v[15]}} : 16'h0;
    for (int i = 0; i < c; i++) begin
      if (k == 0) r = {r[14:0], 1'b0};
      else if (k == 1) r = {r[15], r[15:1]};
      else r = {1'b0, r[15:1]};
    end
    return r;
  endfunction

  function automatic logic [15:0] model(input logic [4:0] op, input logic [15:0] l,
                                        input logic [15:0] r, input logic [15:0] m);
    case (op)
      0: return l & r;
      1: return l | r;
      2: return l ^ r;
      3: return mask(l == r);
      4: return mask(l != r);
      5: return mask($signed(l) >= $signed(r));
      6: return mask($signed(l) > $signed(r));
      7: return mask($signed(l) <= $signed(r));
      8: return mask($signed(l) < $signed(r));
      9: return mask(l >= r);
      10: return mask(l > r);
      11: return mask(l <= r);
      12: return mask(l < r);
      13: return mask(r == 0);
      14: return 16'h0 - r;
      15: return ~r;
      16: return l + r;
      17: return l - r;
      18: return shf(l, r, 0);
      19: return shf(l, r, 1);
      20: return shf(l, r, 2);
      21: return shf(r, m[7:0], 0);
      22: return shf(r, m[7:0], 1);
      23: return shf(r, m[7:0], 2);
      24: return r & m;
      25: return r | m;
      26: return r ^ m;
      27: return mask(r == m);
      28: return mask(r != m);
      29: return mask($signed(r) >= $signed(m));
      30: return mask($signed(r) < $signed(m));
      default: return mask(r < m);
    endcase
  endfunction

  function automatic string tagOf(input logic [4:0] op);
    if (op <= 2) return "R3";
    if (op <= 8) return "R4";
    if (op <= 12) return "R5";
    if (op <= 15) return "R6";
    if (op <= 17) return "R7";
    if (op <= 20) return "R8";
    if (op <= 23) return "R9";
    return "R10";
  endfunction

  task automatic check(input string tag, input logic [15:0] exp);
    checks++;
    if (result !== exp) begin
      errors++;
      $display("FAIL %s: result=%h expected=%h", tag, result, exp);
    end
  endtask

  task automatic apply(input logic [4:0] op, input logic [15:0] l,
                       input logic [15:0] r, input logic [15:0] m);
    opCode = op; leftOp = l; rightOp = r; immOp = m; enable = 1'b1;
    @(posedge clk); #2;
    enable = 1'b0;
    check(tagOf(op), model(op, l, r, m));
  endtask

  initial begin
    logic [15:0] held;
    logic [15:0] pairs [8];
    pairs = '{16'h8000, 16'h7FFF, 16'hFFFF, 16'h0000, 16'h1234, 16'h1234, 16'h0001, 16'hFFFF};
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    #2;
    check("R1", 16'h0000);
    rstN = 1'b1;
    @(posedge clk); #2;
    check("R1", 16'h0000);

    // directed compare corners, each pair both ways
    for (int p = 0; p < 8; p += 2)
      for (int op = 3; op <= 12; op++) begin
        apply(5'(op), pairs[p], pairs[p+1], 16'h0);
        apply(5'(op), pairs[p+1], pairs[p], 16'h0);
      end
    for (int op = 27; op <= 31; op++) begin
      apply(5'(op), 16'h0, 16'h8000, 16'h7FFF);
      apply(5'(op), 16'h0, 16'h5A5A, 16'h5A5A);
    end
    // R6 zero case, R7 wrap
    apply(5'd13, 16'h0, 16'h0000, 16'h0);
    apply(5'd13, 16'h0, 16'h0100, 16'h0);
    apply(5'd14, 16'h0, 16'h8000, 16'h0);
    apply(5'd16, 16'hFFFF, 16'h0002, 16'h0);
    apply(5'd17, 16'h0005, 16'h0007, 16'h0); // R7 order: LL - RR
    // R8/R9 shift boundaries
    foreach (pairs[i]) begin end
    for (int k = 0; k < 3; k++) begin
      apply(5'(18 + k), 16'h8421, 16'd15, 16'h0);
      apply(5'(18 + k), 16'h8421, 16'd16, 16'h0);
      apply(5'(18 + k), 16'h8421, 16'h0100, 16'h0);
      apply(5'(21 + k), 16'h0, 16'h8421, 16'h000F);
      apply(5'(21 + k), 16'h0, 16'h8421, 16'h0010);
      apply(5'(21 + k), 16'h0, 16'h8421, 16'hFF03); // R9 upper byte ignored
    end
    // random sweep
    for (int n = 0; n < 1500; n++)
      apply(5'($urandom_range(0, 31)), 16'($urandom), 16'($urandom),
            16'($urandom_range(0, 3) == 0 ? $urandom_range(0, 20) : $urandom));
    // R2 hold
    held = result;
    opCode = 5'd15; rightOp = result ^ 16'hA5A5; enable = 1'b0;
    repeat (3) @(posedge clk);
    #2;
    check("R2", held);
    apply(5'd15, 16'h0, 16'h00FF, 16'h0);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: result=%h expected=done", result);
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule